// File: doc/BRIEF.md
# Predicated Vector Unsigned Compare Unit

This unit sits in a scalable-vector execution pipe. It takes two vector operands, a governing predicate and an element-size select, and compares the operands element by element as unsigned integers. The compare direction input picks "first operand below second" or "first operand above second". The result is a destination predicate with one bit per vector byte, plus four condition flags. The flags come from a predicate-test reduction over the masked result; they are not arithmetic flags.

Both compare directions share one bank of unsigned "less than" comparators. For the "above" direction an operand swap stage exchanges the two vectors ahead of that bank. All outputs are registered. Every accepted operation takes exactly one cycle, whatever the operand values. A two-state controller tracks whether the output registers hold a fresh result.

The controller states are `ST_IDLE` (no fresh result) and `ST_EMIT` (a result was captured on the last edge). Its transitions are as follows. `TR_ACCEPT` goes to `ST_EMIT` on any edge with `in_valid` high, whichever state it starts from. `TR_DRAIN` goes from `ST_EMIT` to `ST_IDLE` on an edge with `in_valid` low. `TR_WAIT` keeps `ST_IDLE` while `in_valid` stays low.

Top module: `vpred_ucmp_unit`

## Requirements
- R1: With `cmp_hi`=0, the predicate bit of each active element is 1 exactly when the element of `opnd_a` is unsigned-below the matching element of `opnd_b`.
- R2: With `cmp_hi`=1, the predicate bit of each active element is 1 exactly when the element of `opnd_a` is unsigned-above the matching element of `opnd_b`. This equals the R1 compare with the operands swapped.
- R3: `elem_sz` encodes 0=8-bit, 1=16-bit, 2=32-bit and 3=64-bit elements. Element i occupies bytes i·2^s upward, and its predicate bit is byte index i·2^s. An element is active when `gov_pred` has a 1 at that bit. Inactive elements and all non-lowest bits of each byte group read 0.
- R4: `flag_n` equals the result bit of the lowest-numbered active element.
- R5: `flag_z` is 1 exactly when no active element produced a true result.
- R6: `flag_c` is the inverse of the result bit of the highest-numbered active element.
- R7: `flag_v` is always 0.
- R8: `out_valid` is 1 in the cycle after an edge that sampled `in_valid`=1, and 0 otherwise. The latency is always one cycle and never depends on operand data.
- R9: While no new operation is accepted, `res_pred` and all flags hold their last values, even if the inputs change.
- R10: When no element is active, the flags read N=0, Z=1, C=1, V=0 and the predicate is all zero.
- R11: After reset, `out_valid`=0, `res_pred`=0 and the flags read N=0, Z=1, C=1, V=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe; operands sampled on this edge |
| opnd_a | input | VLEN_BITS | First source vector |
| opnd_b | input | VLEN_BITS | Second source vector |
| gov_pred | input | VLEN_BITS/8 | Governing predicate, one bit per byte |
| elem_sz | input | 2 | Element size select (0=8, 1=16, 2=32, 3=64 bits) |
| cmp_hi | input | 1 | 0: a below b; 1: a above b |
| out_valid | output | 1 | Result registers hold a fresh result |
| res_pred | output | VLEN_BITS/8 | Destination predicate |
| flag_n | output | 1 | Result of first active element |
| flag_z | output | 1 | No active element true |
| flag_c | output | 1 | Inverse of result of last active element |
| flag_v | output | 1 | Always zero |

## Verification
A wrong controller state shows on `out_valid` on the next edge. It appears either as a missing pulse after an accepted operation or as a pulse with no operation behind it. A wrong element-size selection or a bad active mask shows on the same edge as predicate bits in non-lowest byte positions or on inactive elements. It also appears as a disagreement between `flag_z` and a zero predicate. The sweep covers every size and both directions with random and extreme data. It compares the predicate and the flags on the first cycle after each operation, so any corruption appears within one operation.

// File: rtl/vpc_pkg.sv
package vpc_pkg;

    typedef enum logic [1:0] {
        ESZ_B = 2'd0,
        ESZ_H = 2'd1,
        ESZ_W = 2'd2,
        ESZ_D = 2'd3
    } esz_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } vpc_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    localparam nzcv_t NZCV_EMPTY = '{n: 1'b0, z: 1'b1, c: 1'b1, v: 1'b0};

endpackage

// File: rtl/vpc_operand_swap.sv
module vpc_operand_swap #(
    parameter int W = 256
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         swap_i,
    output logic [W-1:0] x_o,
    output logic [W-1:0] y_o
);

    // x < y is the only comparison performed downstream;
    // "a above b" becomes "b below a"
    always_comb begin
        if (swap_i) begin
            x_o = b_i;
            y_o = a_i;
        end else begin
            x_o = a_i;
            y_o = b_i;
        end
    end

endmodule

// File: rtl/vpc_elem_compare.sv
module vpc_elem_compare
    import vpc_pkg::*;
#(
    parameter int VLEN_BITS = 256
) (
    input  logic [VLEN_BITS-1:0]   x_i,
    input  logic [VLEN_BITS-1:0]   y_i,
    input  logic [1:0]             esz_i,
    output logic [VLEN_BITS/8-1:0] lt_o,
    output logic [VLEN_BITS/8-1:0] lead_o
);

    localparam int NBYTES = VLEN_BITS / 8;
    localparam int NSIZES = 4;

    logic [NBYTES-1:0] lt_bank   [NSIZES];
    logic [NBYTES-1:0] lead_bank [NSIZES];

    // One comparator bank per element size; only the lowest byte of each
    // element group carries a bit, the rest are tied low.
    for (genvar g = 0; g < NSIZES; g++) begin : g_size
        localparam int GRP = 1 << g;
        localparam int EW  = 8 * GRP;
        for (genvar k = 0; k < NBYTES; k++) begin : g_byte
            if ((k % GRP) == 0) begin : g_lead
                assign lt_bank[g][k]   = x_i[k*8 +: EW] < y_i[k*8 +: EW];
                assign lead_bank[g][k] = 1'b1;
            end else begin : g_tail
                assign lt_bank[g][k]   = 1'b0;
                assign lead_bank[g][k] = 1'b0;
            end
        end
    end

    always_comb begin
        unique case (esz_e'(esz_i))
            ESZ_B: begin lt_o = lt_bank[0]; lead_o = lead_bank[0]; end
            ESZ_H: begin lt_o = lt_bank[1]; lead_o = lead_bank[1]; end
            ESZ_W: begin lt_o = lt_bank[2]; lead_o = lead_bank[2]; end
            ESZ_D: begin lt_o = lt_bank[3]; lead_o = lead_bank[3]; end
            default: begin lt_o = '0; lead_o = '0; end
        endcase
    end

endmodule

// File: rtl/vpc_flag_reduce.sv
module vpc_flag_reduce
    import vpc_pkg::*;
#(
    parameter int NBYTES = 32
) (
    input  logic [NBYTES-1:0] res_i,
    input  logic [NBYTES-1:0] act_i,
    output nzcv_t             flags_o
);

    logic first_hit;
    logic first_val;
    logic last_val;

    always_comb begin
        first_hit = 1'b0;
        first_val = 1'b0;
        last_val  = 1'b0;
        for (int k = 0; k < NBYTES; k++) begin
            if (act_i[k] && !first_hit) begin
                first_hit = 1'b1;
                first_val = res_i[k];
            end
            if (act_i[k]) begin
                last_val = res_i[k];
            end
        end
        flags_o.n = first_val;
        flags_o.z = ~|res_i;
        flags_o.c = ~last_val;
        flags_o.v = 1'b0;
    end

endmodule

// File: rtl/vpred_ucmp_unit.sv
module vpred_ucmp_unit
    import vpc_pkg::*;
#(
    parameter int VLEN_BITS = 256
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [VLEN_BITS-1:0]   opnd_a,
    input  logic [VLEN_BITS-1:0]   opnd_b,
    input  logic [VLEN_BITS/8-1:0] gov_pred,
    input  logic [1:0]             elem_sz,
    input  logic                   cmp_hi,
    output logic                   out_valid,
    output logic [VLEN_BITS/8-1:0] res_pred,
    output logic                   flag_n,
    output logic                   flag_z,
    output logic                   flag_c,
    output logic                   flag_v
);

    localparam int NBYTES = VLEN_BITS / 8;

    logic [VLEN_BITS-1:0] cmp_x;
    logic [VLEN_BITS-1:0] cmp_y;
    logic [NBYTES-1:0]    lt_raw;
    logic [NBYTES-1:0]    lead_mask;
    logic [NBYTES-1:0]    act_mask;
    logic [NBYTES-1:0]    pred_d;
    nzcv_t                flags_d;

    vpc_operand_swap #(.W(VLEN_BITS)) swap_i (
        .a_i    (opnd_a),
        .b_i    (opnd_b),
        .swap_i (cmp_hi),
        .x_o    (cmp_x),
        .y_o    (cmp_y)
    );

    vpc_elem_compare #(.VLEN_BITS(VLEN_BITS)) cmp_i (
        .x_i    (cmp_x),
        .y_i    (cmp_y),
        .esz_i  (elem_sz),
        .lt_o   (lt_raw),
        .lead_o (lead_mask)
    );

    assign act_mask = gov_pred & lead_mask;
    assign pred_d   = lt_raw & act_mask;

    vpc_flag_reduce #(.NBYTES(NBYTES)) red_i (
        .res_i   (pred_d),
        .act_i   (act_mask),
        .flags_o (flags_d)
    );

    // ---- controller ----
    vpc_state_e state_q;
    vpc_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;  // TR_ACCEPT / TR_WAIT
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;  // TR_ACCEPT / TR_DRAIN
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---- result registers: loaded only on accept, fixed latency ----
    logic [NBYTES-1:0] pred_q;
    nzcv_t             flags_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pred_q  <= '0;
            flags_q <= NZCV_EMPTY;
        end else if (in_valid) begin
            pred_q  <= pred_d;
            flags_q <= flags_d;
        end
    end

    always_comb begin
        out_valid = (state_q == ST_EMIT);
        res_pred  = pred_q;
        flag_n    = flags_q.n;
        flag_z    = flags_q.z;
        flag_c    = flags_q.c;
        flag_v    = flags_q.v;
    end

endmodule

// File: rtl/vpred_ucmp_unit_chk.sv
module vpred_ucmp_unit_chk #(
    parameter int NBYTES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [NBYTES-1:0] gov_pred,
    input logic [1:0]        elem_sz,
    input logic              out_valid,
    input logic [NBYTES-1:0] res_pred,
    input logic              flag_n,
    input logic              flag_z,
    input logic              flag_c,
    input logic              flag_v
);

    logic [NBYTES-1:0] gp_q;
    logic [1:0]        sz_q;
    logic [NBYTES-1:0] allowed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gp_q <= '0;
            sz_q <= '0;
        end else if (in_valid) begin
            gp_q <= gov_pred;
            sz_q <= elem_sz;
        end
    end

    always_comb begin
        for (int k = 0; k < NBYTES; k++) begin
            allowed[k] = gp_q[k] && ((k % (1 << sz_q)) == 0);
        end
    end

    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r3_inactive_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_pred & ~allowed) == '0);

    a_r5_z_matches_pred: assert property (@(posedge clk) disable iff (!rst_n)
        flag_z == (res_pred == '0));

    a_r4_n_needs_true: assert property (@(posedge clk) disable iff (!rst_n)
        flag_n |-> (res_pred != '0));

    a_r6_c_needs_true: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_c |-> (res_pred != '0));

    a_r7_v_low: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !flag_v);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_pred) && $stable(flag_n)
                       && $stable(flag_z) && $stable(flag_c)));

    a_r10_empty_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (gp_q == '0) |-> (!flag_n && flag_z && flag_c));

endmodule

bind vpred_ucmp_unit vpred_ucmp_unit_chk #(.NBYTES(NBYTES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .gov_pred  (gov_pred),
    .elem_sz   (elem_sz),
    .out_valid (out_valid),
    .res_pred  (res_pred),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_c    (flag_c),
    .flag_v    (flag_v)
);

// File: tb/vpred_ucmp_unit_tb.sv
module vpred_ucmp_unit_tb_top;

    localparam int VL = 128;
    localparam int NB = VL / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [VL-1:0] opnd_a = '0;
    logic [VL-1:0] opnd_b = '0;
    logic [NB-1:0] gov_pred = '0;
    logic [1:0]    elem_sz = '0;
    logic          cmp_hi = 1'b0;
    logic          out_valid;
    logic [NB-1:0] res_pred;
    logic          flag_n, flag_z, flag_c, flag_v;

    int checks = 0;
    int failures = 0;
    logic [63:0] seed = 64'h9E3779B97F4A7C15;

    logic [NB-1:0] exp_pred;
    logic          exp_n, exp_z, exp_c;

    always #5 clk = ~clk;

    vpred_ucmp_unit #(.VLEN_BITS(VL)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .gov_pred(gov_pred),
        .elem_sz(elem_sz), .cmp_hi(cmp_hi),
        .out_valid(out_valid), .res_pred(res_pred),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
    );

    function automatic logic [63:0] nxt(input logic [63:0] s);
        logic [63:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 7);
        t = t ^ (t << 17);
        return t;
    endfunction

    task automatic rnd128(output logic [VL-1:0] v);
        seed = nxt(seed); v[63:0]   = seed;
        seed = nxt(seed); v[127:64] = seed;
    endtask

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected result from the requirements, arithmetic per element
    task automatic model(input logic [VL-1:0] a, input logic [VL-1:0] b,
                         input logic [NB-1:0] gp, input int sz, input logic hi);
        int          w;
        logic [63:0] m, ea, eb;
        logic        r, seen;
        w = 8 << sz;
        m = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
        exp_pred = '0; exp_n = 1'b0; exp_c = 1'b1; seen = 1'b0;
        for (int i = 0; i < (NB >> sz); i++) begin
            int p;
            p  = i << sz;
            ea = 64'(a >> (i * w)) & m;
            eb = 64'(b >> (i * w)) & m;
            r  = hi ? (ea > eb) : (ea < eb);
            if (gp[p]) begin
                exp_pred[p] = r;
                if (!seen) exp_n = r;
                seen  = 1'b1;
                exp_c = !r;
            end
        end
        exp_z = (exp_pred == '0);
    endtask

    task automatic apply(input logic [VL-1:0] a, input logic [VL-1:0] b,
                         input logic [NB-1:0] gp, input int sz, input logic hi);
        opnd_a = a; opnd_b = b; gov_pred = gp; elem_sz = 2'(sz); cmp_hi = hi;
        in_valid = 1'b1;
        model(a, b, gp, sz, hi);
        @(negedge clk);
        check("R8 out_valid after accept", 128'(out_valid), 128'd1);
        check(hi ? "R2/R3 predicate above" : "R1/R3 predicate below",
              128'(res_pred), 128'(exp_pred));
        check("R4 flag_n", 128'(flag_n), 128'(exp_n));
        check("R5 flag_z", 128'(flag_z), 128'(exp_z));
        check("R6 flag_c", 128'(flag_c), 128'(exp_c));
        check("R7 flag_v", 128'(flag_v), 128'd0);
        if (gp == '0)
            check("R10 empty flags", 128'({res_pred, flag_n, flag_z, flag_c, flag_v}),
                  128'({{NB{1'b0}}, 4'b0110}));
    endtask

    task automatic idle_hold();
        logic [VL-1:0] r;
        in_valid = 1'b0;
        rnd128(r); opnd_a = r;
        rnd128(r); opnd_b = r;
        gov_pred = r[NB-1:0]; elem_sz = r[21:20]; cmp_hi = r[30];
        @(negedge clk);
        check("R8 out_valid drops", 128'(out_valid), 128'd0);
        check("R9 hold", 128'({res_pred, flag_n, flag_z, flag_c, flag_v}),
              128'({exp_pred, exp_n, exp_z, exp_c, 1'b0}));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [VL-1:0] ra, rb, rg;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R11 reset state",
              128'({out_valid, res_pred, flag_n, flag_z, flag_c, flag_v}),
              128'({1'b0, {NB{1'b0}}, 4'b0110}));
        for (int sz = 0; sz < 4; sz++) begin
            for (int hi = 0; hi < 2; hi++) begin
                apply('0, '0, '1, sz, 1'(hi));               // equal: all false
                idle_hold();
                apply('1, '0, '1, sz, 1'(hi));               // extremes
                apply('0, '1, '1, sz, 1'(hi));               // back to back
                idle_hold();
                rnd128(ra);
                apply(ra, ra, '1, sz, 1'(hi));               // equal random
                apply(ra, ~ra, '0, sz, 1'(hi));              // R10 no active
                idle_hold();
                for (int t = 0; t < 40; t++) begin
                    rnd128(ra); rnd128(rb); rnd128(rg);
                    if (t % 3 == 0) rb = ra ^ (VL'(1) << (t * 3));  // near-equal
                    apply(ra, rb, rg[NB-1:0], sz, 1'(hi));
                    if (t % 2 == 1) idle_hold();
                end
            end
        end
        // lone active element at each end
        apply('0, '1, NB'(1), 0, 1'b0);
        apply('0, '1, NB'(1) << (NB - 1), 0, 1'b0);
        apply('1, '0, NB'(1) << (NB - 8), 3, 1'b0);
        idle_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule